// File: doc/BRIEF.md
# Watchdog with Escalating Configuration Recovery

This block protects a risky configuration change, typically a move to a new clock frequency, against a hang. Software first programs an interval, then sets the arm bit and applies the new setting. Once the system is confirmed healthy, software clears the arm bit. If that does not happen in time, the block drives an active-low reset pulse of fixed width. It also moves the configuration-source select away from the programmed target setting.

Recovery escalates across successive expirations. The first expiry selects the stored fallback setting, unless the fallback-mode input asks for a direct return to the hardware strap setting. Any later expiry selects the strap setting, and the select then stays there. The escalation stage survives the watchdog's own reset pulse and clears only on power-on reset.

Time is measured in strobes of a 1 ms tick input. The timeout in ticks is the 6-bit interval count × the unit (250, 500, 1000 or 2000 ms, chosen by a 2-bit code) scaled by `UNIT_TICKS`. Every input is a plain level or strobe and every output is a plain level, so there is no handshake and no back-pressure.

Top module: `wdt_fallback`

## Requirements
- R1: While power-on reset is asserted and right after it, `wd_rst_n` is 1, `cfg_src` is 0 (target setting) and `wd_running` is 0.
- R2: With `wd_arm` held at 1 and a tick in every cycle, expiry happens on the tick that completes `interval × 2^unit_sel × UNIT_TICKS` ticks, counted from the first cycle in which `wd_arm` is 1. Unit codes 0, 1, 2 and 3 stand for 1×, 2×, 4× and 8× the 250 ms base.
- R3: Clearing `wd_arm` before expiry discards the accumulated count, and no pulse is produced. Re-arming starts a full interval again.
- R4: An interval count of 0 never expires, however long the block stays armed.
- R5: On expiry, `wd_rst_n` goes low in the next cycle and stays low for exactly `PULSE_TICKS` ticks.
- R6: The first expiry with `use_fallback`=1 changes `cfg_src` to 1 (fallback setting) in the same cycle that `wd_rst_n` falls.
- R7: The first expiry with `use_fallback`=0 changes `cfg_src` directly to 2 (strap setting).
- R8: An expiry while `cfg_src` is 1 moves it to 2. An expiry while it is 2 leaves it at 2. `cfg_src` never moves back except on power-on reset.
- R9: The escalation stage is cleared only by power-on reset. The watchdog pulse and the arm bit do not clear it.
- R10: `wd_running` is 1 exactly when `wd_arm` is 1, the interval count is nonzero and no pulse is in progress.
- R11: No ticks are counted during the pulse. If the block is still armed when the pulse ends, a full new interval starts.
- R12: Only cycles carrying `ms_tick`=1 advance the timer. Time without ticks adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| wd_arm | input | 1 | Arm bit; 1 = timer running |
| unit_sel | input | 2 | Time unit code: 0=250 ms, 1=500 ms, 2=1 s, 3=2 s |
| interval | input | 6 | Interval count in units; 0 = never expires |
| use_fallback | input | 1 | First expiry: 1 = fallback setting, 0 = strap setting |
| wd_rst_n | output | 1 | Watchdog reset pulse, active low |
| cfg_src | output | 2 | Active setting: 0=target, 1=fallback, 2=strap |
| wd_running | output | 1 | Timer armed and counting |

## Verification
The embedded properties check the following on every cycle:
- `cfg_src` never steps backward.
- `cfg_src` changes only in the cycle where the reset pulse begins.
- The pulse counter stays inside its width.
- A zero interval never produces an expiry.
- The running flag is low while the pulse is asserted.

The directed scenarios are needed for everything that depends on exact counts:
- the expiry cycle for each unit;
- the pulse width;
- the full restart after a cancel or after a pulse;
- the two escalation paths, chosen by the fallback-mode bit;
- the stage staying in place until the next power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_TARGET   = 2'd0,
    SRC_FALLBACK = 2'd1,
    SRC_STRAP    = 2'd2
  } cfg_src_e;
endpackage

// File: rtl/wdt_limit.sv
// Turns unit code and interval count into a timeout measured in ticks.
module wdt_limit #(
  parameter int IVL_W      = 6,
  parameter int UNIT_W     = 2,
  parameter int UNIT_TICKS = 250,
  localparam int LIM_W     = IVL_W + (2**UNIT_W - 1) + $clog2(UNIT_TICKS + 1)
) (
  input  logic [UNIT_W-1:0] unit_sel_i,
  input  logic [IVL_W-1:0]  interval_i,
  output logic [LIM_W-1:0]  limit_o
);
  logic [LIM_W-1:0] scaled;

  always_comb begin
    scaled  = LIM_W'(interval_i) << unit_sel_i;
    limit_o = scaled * LIM_W'(UNIT_TICKS);
  end
endmodule

// File: rtl/wdt_timer.sv
// Counts ticks while armed and flags the expiry tick.
module wdt_timer #(
  parameter int LIM_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             pulse_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expire_o,
  output logic             running_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             reached;

  always_comb begin
    running_o = arm_i && (limit_i != '0) && !pulse_i;
    reached   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
    expire_o  = running_o && tick_i && reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!running_o || expire_o) cnt_q <= '0;
    else if (tick_i)                cnt_q <= cnt_q + 1'b1;
  end

  // R4: a zero interval gives no expiry
  p_zero_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |-> !expire_o);
endmodule

// File: rtl/wdt_pulse.sv
// Generates the fixed-width active reset window in ticks.
module wdt_pulse #(
  parameter int PULSE_TICKS = 500,
  localparam int PW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (active_o && tick_i) begin
      if (cnt_q == PW'(PULSE_TICKS - 1)) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: the width counter never passes the programmed width
  p_pulse_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PW'(PULSE_TICKS));
endmodule

// File: rtl/wdt_escalate.sv
// Stage tracker: target -> fallback -> strap, cleared only by power-on reset.
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire_i,
  input  logic     use_fb_i,
  output cfg_src_e src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_o <= SRC_TARGET;
    else if (expire_i) begin
      unique case (src_o)
        SRC_TARGET: src_o <= use_fb_i ? SRC_FALLBACK : SRC_STRAP;
        default:    src_o <= SRC_STRAP;
      endcase
    end
  end
endmodule

// File: rtl/wdt_fallback.sv
module wdt_fallback
  import wdt_pkg::*;
#(
  parameter int IVL_W       = 6,
  parameter int UNIT_W      = 2,
  parameter int UNIT_TICKS  = 250,
  parameter int PULSE_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              wd_arm,
  input  logic [UNIT_W-1:0] unit_sel,
  input  logic [IVL_W-1:0]  interval,
  input  logic              use_fallback,
  output logic              wd_rst_n,
  output logic [1:0]        cfg_src,
  output logic              wd_running
);
  localparam int LIM_W = IVL_W + (2**UNIT_W - 1) + $clog2(UNIT_TICKS + 1);

  logic [LIM_W-1:0] limit;
  logic             expire;
  logic             pulse_active;
  cfg_src_e         src;

  wdt_limit #(.IVL_W(IVL_W), .UNIT_W(UNIT_W), .UNIT_TICKS(UNIT_TICKS)) u_limit (
    .unit_sel_i (unit_sel),
    .interval_i (interval),
    .limit_o    (limit)
  );

  wdt_timer #(.LIM_W(LIM_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (ms_tick),
    .arm_i     (wd_arm),
    .pulse_i   (pulse_active),
    .limit_i   (limit),
    .expire_o  (expire),
    .running_o (wd_running)
  );

  wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (ms_tick),
    .start_i  (expire),
    .active_o (pulse_active)
  );

  wdt_escalate u_esc (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .use_fb_i (use_fallback),
    .src_o    (src)
  );

  assign wd_rst_n = !pulse_active;
  assign cfg_src  = src;

  // R8: the source select never steps back while out of reset
  p_src_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_src >= $past(cfg_src));

  // R6: the source select changes only when a reset pulse starts
  p_src_change_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src != $past(cfg_src)) |-> $fell(wd_rst_n));

  // R10: never reported running while the pulse is driven
  p_idle_in_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |-> !wd_running);
endmodule

// File: tb/wdt_fallback_test.sv
module wdt_fallback_test;
  localparam int UT = 2;
  localparam int PT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b1;
  logic       wd_arm = 1'b0;
  logic [1:0] unit_sel = '0;
  logic [5:0] interval = '0;
  logic       use_fallback = 1'b0;
  logic       wd_rst_n;
  logic [1:0] cfg_src;
  logic       wd_running;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wdt_fallback #(.UNIT_TICKS(UT), .PULSE_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_arm(wd_arm),
    .unit_sel(unit_sel), .interval(interval), .use_fallback(use_fallback),
    .wd_rst_n(wd_rst_n), .cfg_src(cfg_src), .wd_running(wd_running)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; wd_arm = 1'b0; ms_tick = 1'b1;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    edges(2);
    check("R1 wd_rst_n in reset", wd_rst_n, 1);
    check("R1 cfg_src in reset", cfg_src, 0);
    rst_n = 1'b1;
    edges(1);
    check("R1 wd_running after reset", wd_running, 0);
    check("R1 cfg_src after reset", cfg_src, 0);
  endtask

  // limit = 3 * 2 * 2 = 12 ticks
  task automatic t_first_fallback();
    interval = 6'd3; unit_sel = 2'd1; use_fallback = 1'b1; wd_arm = 1'b1;
    edges(1);
    check("R10 running while armed", wd_running, 1);
    edges(10);
    check("R2 no pulse one tick early", wd_rst_n, 1);
    check("R6 target before expiry", cfg_src, 0);
    edges(1);
    check("R2 pulse on limit tick", wd_rst_n, 0);
    check("R6 fallback on first expiry", cfg_src, 1);
    check("R10 not running in pulse", wd_running, 0);
  endtask

  task automatic t_pulse_width();
    edges(PT - 1);
    check("R5 pulse still low at last tick", wd_rst_n, 0);
    edges(1);
    check("R5 pulse released after width", wd_rst_n, 1);
  endtask

  task automatic t_second_expiry();
    edges(11);
    check("R11 full interval after pulse", wd_rst_n, 1);
    check("R9 stage kept after pulse", cfg_src, 1);
    edges(1);
    check("R8 second expiry pulses", wd_rst_n, 0);
    check("R8 fallback escalates to strap", cfg_src, 2);
  endtask

  task automatic t_strap_hold();
    edges(PT + 12);
    check("R8 third expiry pulses", wd_rst_n, 0);
    check("R8 strap held", cfg_src, 2);
    wd_arm = 1'b0;
    edges(PT + 20);
    check("R9 arm clear keeps stage", cfg_src, 2);
  endtask

  task automatic t_por_clears();
    por();
    check("R9 power-on clears stage", cfg_src, 0);
    check("R1 pulse idle after power-on", wd_rst_n, 1);
  endtask

  // limit = 3 * 1 * 2 = 6 ticks
  task automatic t_cancel_direct_strap();
    interval = 6'd3; unit_sel = 2'd0; use_fallback = 1'b0; wd_arm = 1'b1;
    edges(5);
    wd_arm = 1'b0;
    edges(1);
    check("R3 cancel gives no pulse", wd_rst_n, 1);
    check("R10 not running when disarmed", wd_running, 0);
    wd_arm = 1'b1;
    edges(5);
    check("R3 count restarted", wd_rst_n, 1);
    edges(1);
    check("R3 expiry after full interval", wd_rst_n, 0);
    check("R7 direct strap on first expiry", cfg_src, 2);
    wd_arm = 1'b0;
  endtask

  task automatic t_zero_interval();
    por();
    interval = 6'd0; unit_sel = 2'd3; wd_arm = 1'b1;
    edges(200);
    check("R4 zero interval no pulse", wd_rst_n, 1);
    check("R4 zero interval cfg", cfg_src, 0);
    check("R10 zero interval not running", wd_running, 0);
    wd_arm = 1'b0;
  endtask

  // limit = 1 * 8 * 2 = 16 ticks
  task automatic t_tick_gate();
    por();
    interval = 6'd1; unit_sel = 2'd3; use_fallback = 1'b1;
    ms_tick = 1'b0; wd_arm = 1'b1;
    edges(50);
    check("R12 no expiry without ticks", wd_rst_n, 1);
    ms_tick = 1'b1;
    edges(15);
    check("R12 tick 15 of 16 no pulse", wd_rst_n, 1);
    edges(1);
    check("R2 unit 3 expires on tick 16", wd_rst_n, 0);
    check("R6 fallback after tick-gated run", cfg_src, 1);
    wd_arm = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_first_fallback();
    t_pulse_width();
    t_second_expiry();
    t_strap_hold();
    t_por_clears();
    t_cancel_direct_strap();
    t_zero_interval();
    t_tick_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        edges(200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule